// File: doc/BRIEF.md
# General-Purpose I/O Controller with Per-Pin Interrupt Modes

This block is a register-mapped general-purpose I/O controller. It has one narrow port (8 pins by default) that can raise interrupts, and a set of wide plain ports (four ports of 18 pins by default). Each port has three registers: an output value, a direction (1 means the pin drives) and a read-only view of its input pins. Set and clear helper addresses change only the bits that a per-port changeable mask, fixed at build time, allows. A direct write to the output or direction register changes every bit.

The narrow port's pins pass through a two-flop synchroniser. Each pin has a 3-bit mode field that chooses how the pin raises an interrupt. Level modes report the live condition of the pin. Edge modes set a sticky pending bit that holds until software writes a one to the acknowledge register. A mask register gates the status, and the single interrupt output is the OR of the masked bits.

Access is through a single-cycle bus. A write takes effect at the clock edge while `reg_wr` is high. Read data is combinational from `reg_addr`.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every output value, every direction bit, the mode register and the mask are zero, and `irq` is low.
- R2: Address map. Port block p sits at word address 8·p, where p = 0 is the narrow port and p = 1..4 are the wide ports. The offsets within a block are: 0 output value, 1 input pins, 2 direction, 3 output set, 4 output clear, 5 direction set, 6 direction clear. The interrupt block starts at 8·(number of wide ports + 1), which is 40 by default. Its offsets are: 0 mode, 1 mask, 2 masked status, 3 acknowledge, 4 unmasked status. A write to offset 0 or 2 of a port block loads every bit of that port.
- R3: A write to a set offset forces to 1 every bit that is 1 in both the write data and the changeable mask. All other bits keep their value.
- R4: A write to a clear offset forces to 0 every bit that is 1 in both the write data and the changeable mask. All other bits keep their value.
- R5: Offset 1 returns the pin values through two flops. A pin change presented before clock edge k reads back after edge k+1, and not after edge k.
- R6: The mode of narrow pin i is held in bits 3i+2..3i of the mode register. The codes are 0 off, 1 high, 2 low, 3 always, 4 rising, 5 falling, 6 any edge. Code 7 behaves as off.
- R7: In the high, low and always modes the status bit follows the synchronised level condition, with no latching. The bit clears once the condition ends.
- R8: In the edge modes a qualifying edge on the synchronised pin sets a pending bit. The bit is visible one cycle after the new level reaches the input register, and it stays set after the pin returns.
- R9: Writing the acknowledge register clears each pending bit written as 1. Bits written as 0 are unaffected. If a new edge occurs in the same cycle as the acknowledge, the new edge wins.
- R10: The masked status equals the unmasked status ANDed with the mask. `irq` is the OR of the masked status. Clearing a mask bit removes that pin's contribution.
- R11: The set, clear and acknowledge offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W (6) | Word address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, combinational from reg_addr |
| pa_in | input | PA_W (8) | Narrow port pin inputs |
| pa_out | output | PA_W (8) | Narrow port output values |
| pa_oe | output | PA_W (8) | Narrow port drive enables |
| pw_in | input | NWIDE·PW_W (72) | Wide port pin inputs, port 1 in the lowest slice |
| pw_out | output | NWIDE·PW_W (72) | Wide port output values |
| pw_oe | output | NWIDE·PW_W (72) | Wide port drive enables |
| irq | output | 1 | OR of the masked status |

## Verification
Register writes, set and clear included, are visible on the outputs and on read-back at the first sample after the write edge. An input change is due two edges later, a level status at the same point, and an edge pending bit one edge after that. The bench drives pins and bus at falling edges and counts whole cycles to each sample. It reads one cycle early to confirm that the input register and the pending bit are not yet set. The acknowledge-versus-edge collision is placed on the exact cycle in which the edge is live.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
    // offsets inside a port block
    localparam logic [2:0] OFS_DOUT = 3'd0;
    localparam logic [2:0] OFS_DIN  = 3'd1;
    localparam logic [2:0] OFS_OE   = 3'd2;
    localparam logic [2:0] OFS_DSET = 3'd3;
    localparam logic [2:0] OFS_DCLR = 3'd4;
    localparam logic [2:0] OFS_OSET = 3'd5;
    localparam logic [2:0] OFS_OCLR = 3'd6;
    // offsets inside the interrupt block
    localparam int IRQ_CFG   = 0;
    localparam int IRQ_MASK  = 1;
    localparam int IRQ_MSTAT = 2;
    localparam int IRQ_ACK   = 3;
    localparam int IRQ_RAW   = 4;
    // pin mode codes
    localparam logic [2:0] MD_OFF    = 3'd0;
    localparam logic [2:0] MD_HIGH   = 3'd1;
    localparam logic [2:0] MD_LOW    = 3'd2;
    localparam logic [2:0] MD_ALWAYS = 3'd3;
    localparam logic [2:0] MD_RISE   = 3'd4;
    localparam logic [2:0] MD_FALL   = 3'd5;
    localparam logic [2:0] MD_ANY    = 3'd6;
    localparam int MODE_W = 3;
endpackage

// File: rtl/gpio_ctrl_sync.sv
module gpio_ctrl_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/gpio_ctrl_port.sv
module gpio_ctrl_port
    import gpio_ctrl_pkg::*;
#(
    parameter int           W   = 18,
    parameter logic [W-1:0] CHG = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   ofs,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dout,
    output logic [W-1:0] oe
);
    typedef struct packed {
        logic [W-1:0] dout;
        logic [W-1:0] oe;
    } port_t;

    port_t        st_d, st_q;
    logic [W-1:0] allowed;

    assign allowed = wdata & CHG;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (ofs)
                OFS_DOUT: st_d.dout = wdata;
                OFS_OE:   st_d.oe   = wdata;
                OFS_DSET: st_d.dout = st_q.dout | allowed;
                OFS_DCLR: st_d.dout = st_q.dout & ~allowed;
                OFS_OSET: st_d.oe   = st_q.oe | allowed;
                OFS_OCLR: st_d.oe   = st_q.oe & ~allowed;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.dout;
    assign oe   = st_q.oe;
endmodule

// File: rtl/gpio_ctrl_irq.sv
module gpio_ctrl_irq
    import gpio_ctrl_pkg::*;
#(
    parameter int N = 8,
    localparam int CW = N * MODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pin,
    input  logic [CW-1:0] cfg,
    input  logic          ack_we,
    input  logic [N-1:0]  ack,
    output logic [N-1:0]  raw_stat
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } irq_t;

    irq_t         st_d, st_q;
    logic [N-1:0] lvl;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin;
        lvl       = '0;
        for (int i = 0; i < N; i++) begin
            logic [2:0] md;
            logic       rise, fall, ev;
            md   = cfg[i*MODE_W +: MODE_W];
            rise = pin[i] & ~st_q.prev[i];
            fall = ~pin[i] & st_q.prev[i];
            ev   = 1'b0;
            case (md)
                MD_HIGH:   lvl[i] = pin[i];
                MD_LOW:    lvl[i] = ~pin[i];
                MD_ALWAYS: lvl[i] = 1'b1;
                MD_RISE:   ev = rise;
                MD_FALL:   ev = fall;
                MD_ANY:    ev = rise | fall;
                default:   ;
            endcase
            st_d.pend[i] = ev | (st_q.pend[i] & ~(ack_we & ack[i]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_stat = st_q.pend | lvl;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int                    PA_W   = 8,
    parameter int                    PW_W   = 18,
    parameter int                    NWIDE  = 4,
    parameter int                    ADDR_W = 6,
    parameter int                    DATA_W = 32,
    parameter logic [PA_W-1:0]       CHG_A  = '1,
    parameter logic [NWIDE*PW_W-1:0] CHG_W  = '1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    input  logic [PA_W-1:0]         pa_in,
    output logic [PA_W-1:0]         pa_out,
    output logic [PA_W-1:0]         pa_oe,
    input  logic [NWIDE*PW_W-1:0]   pw_in,
    output logic [NWIDE*PW_W-1:0]   pw_out,
    output logic [NWIDE*PW_W-1:0]   pw_oe,
    output logic                    irq
);
    localparam int NPORT    = NWIDE + 1;
    localparam int IRQ_BASE = NPORT * 8;
    localparam int CFG_W    = PA_W * MODE_W;
    localparam int BLK_W    = ADDR_W - 3;
    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(IRQ_BASE + IRQ_CFG);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(IRQ_BASE + IRQ_MASK);
    localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(IRQ_BASE + IRQ_MSTAT);
    localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(IRQ_BASE + IRQ_ACK);
    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(IRQ_BASE + IRQ_RAW);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [PA_W-1:0]  mask;
    } ictl_t;

    ictl_t                 ic_d, ic_q;
    logic [BLK_W-1:0]      blk;
    logic [2:0]            ofs;
    logic [PA_W-1:0]       pa_s, raw_stat, masked;
    logic [NWIDE*PW_W-1:0] pw_s;
    logic                  ack_we;
    logic                  unused_wdata;

    assign blk          = reg_addr[ADDR_W-1:3];
    assign ofs          = reg_addr[2:0];
    assign ack_we       = reg_wr && (reg_addr == A_ACK);
    assign unused_wdata = ^reg_wdata;

    gpio_ctrl_sync #(.W(PA_W)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .din(pa_in), .dout(pa_s));

    gpio_ctrl_sync #(.W(NWIDE*PW_W)) u_sync_w (
        .clk(clk), .rst_n(rst_n), .din(pw_in), .dout(pw_s));

    gpio_ctrl_port #(.W(PA_W), .CHG(CHG_A)) u_port_a (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr && (blk == '0)),
        .ofs(ofs), .wdata(reg_wdata[PA_W-1:0]),
        .dout(pa_out), .oe(pa_oe));

    for (genvar g = 0; g < NWIDE; g++) begin : g_wide
        gpio_ctrl_port #(.W(PW_W), .CHG(CHG_W[g*PW_W +: PW_W])) u_port (
            .clk(clk), .rst_n(rst_n),
            .wr_en(reg_wr && (blk == BLK_W'(g + 1))),
            .ofs(ofs), .wdata(reg_wdata[PW_W-1:0]),
            .dout(pw_out[g*PW_W +: PW_W]), .oe(pw_oe[g*PW_W +: PW_W]));
    end

    gpio_ctrl_irq #(.N(PA_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .pin(pa_s), .cfg(ic_q.cfg),
        .ack_we(ack_we), .ack(reg_wdata[PA_W-1:0]), .raw_stat(raw_stat));

    always_comb begin
        ic_d = ic_q;
        if (reg_wr && reg_addr == A_CFG)  ic_d.cfg  = reg_wdata[CFG_W-1:0];
        if (reg_wr && reg_addr == A_MASK) ic_d.mask = reg_wdata[PA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ic_q <= '0;
        else        ic_q <= ic_d;
    end

    assign masked = raw_stat & ic_q.mask;
    assign irq    = |masked;

    always_comb begin
        reg_rdata = '0;
        if (blk == '0) begin
            case (ofs)
                OFS_DOUT: reg_rdata = DATA_W'(pa_out);
                OFS_DIN:  reg_rdata = DATA_W'(pa_s);
                OFS_OE:   reg_rdata = DATA_W'(pa_oe);
                default:  ;
            endcase
        end
        for (int p = 0; p < NWIDE; p++) begin
            if (blk == BLK_W'(p + 1)) begin
                case (ofs)
                    OFS_DOUT: reg_rdata = DATA_W'(pw_out[p*PW_W +: PW_W]);
                    OFS_DIN:  reg_rdata = DATA_W'(pw_s[p*PW_W +: PW_W]);
                    OFS_OE:   reg_rdata = DATA_W'(pw_oe[p*PW_W +: PW_W]);
                    default:  ;
                endcase
            end
        end
        if (reg_addr == A_CFG)   reg_rdata = DATA_W'(ic_q.cfg);
        if (reg_addr == A_MASK)  reg_rdata = DATA_W'(ic_q.mask);
        if (reg_addr == A_MSTAT) reg_rdata = DATA_W'(masked);
        if (reg_addr == A_RAW)   reg_rdata = DATA_W'(raw_stat);
    end
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
    parameter int              PA_W   = 8,
    parameter int              NWIDE  = 4,
    parameter int              ADDR_W = 6,
    parameter int              DATA_W = 32,
    parameter logic [PA_W-1:0] CHG_A  = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [PA_W-1:0]   pa_in,
    input logic [PA_W-1:0]   pa_out,
    input logic [PA_W-1:0]   pa_oe,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'((NWIDE + 1) * 8 + 1);

    logic [1:0] since_rst;
    logic       unused_chk;
    assign unused_chk = ^{reg_wdata, reg_rdata};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd0) |-> (pa_out == '0 && pa_oe == '0 && !irq));

    p_set_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_SET) |=> ((pa_out & $past(pa_out)) == $past(pa_out)));

    p_set_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_SET) |=> ((pa_out & ~CHG_A) == ($past(pa_out) & ~CHG_A)));

    p_clr_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CLR) |=> ((pa_out & ~CHG_A) == ($past(pa_out) & ~CHG_A)));

    p_din_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && reg_addr == A_DIN) |-> (reg_rdata[PA_W-1:0] == $past(pa_in, 2)));

    p_mask_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_MASK && reg_wdata[PA_W-1:0] == '0) |=> !irq);
endmodule

bind gpio_ctrl gpio_ctrl_chk #(
    .PA_W(PA_W), .NWIDE(NWIDE), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHG_A(CHG_A)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pa_in(pa_in),
    .pa_out(pa_out), .pa_oe(pa_oe), .irq(irq)
);

// File: tb/gpio_ctrl_test.sv
`timescale 1ns/1ps
module gpio_ctrl_test;
    localparam logic [7:0]  CHG_A = 8'h3C;
    localparam logic [71:0] CHG_W = {18'h3FFFF, 18'h00F0F, 18'h2AAAA, 18'h15555};
    localparam int A_CFG = 40, A_MASK = 41, A_MSTAT = 42, A_ACK = 43, A_RAW = 44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  pa_in = '0, pa_out, pa_oe;
    logic [71:0] pw_in = '0, pw_out, pw_oe;
    logic        irq;
    int          total = 0, bad = 0;

    gpio_ctrl #(.CHG_A(CHG_A), .CHG_W(CHG_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pa_in(pa_in),
        .pa_out(pa_out), .pa_oe(pa_oe), .pw_in(pw_in), .pw_out(pw_out),
        .pw_oe(pw_oe), .irq(irq));

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        reg_addr = 6'(a);
        #0.5;
        v = reg_rdata;
    endtask

    function automatic logic [7:0] f_ev(input int m, input logic [7:0] o, input logic [7:0] n);
        case (m)
            4: return n & ~o;
            5: return o & ~n;
            6: return o ^ n;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] f_lvl(input int m, input logic [7:0] n);
        case (m)
            1: return n;
            2: return ~n;
            3: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  pend, cur;
        logic [7:0]  pats [5];
        pats = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h0F};

        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk("R1 pa_out", 32'(pa_out), 0);
        chk("R1 pa_oe", 32'(pa_oe), 0);
        chk("R1 pw_out", 32'(|pw_out), 0);
        chk("R1 irq", 32'(irq), 0);
        rd(A_CFG, v);  chk("R1 cfg", v, 0);
        rd(A_MASK, v); chk("R1 mask", v, 0);

        // R2 full writes, R3/R4 gated set and clear on the narrow port
        wr(0, 32'hFFFF_FFFF);
        chk("R2 pa_out full", 32'(pa_out), 32'hFF);
        rd(0, v); chk("R2 pa_out readback", v, 32'hFF);
        wr(4, 32'hFF);
        chk("R4 clear gated", 32'(pa_out), 32'(8'hFF & ~CHG_A));
        wr(3, 32'h0F);
        chk("R3 set gated", 32'(pa_out), 32'((8'hFF & ~CHG_A) | (8'h0F & CHG_A)));
        wr(2, 32'h81);
        chk("R2 pa_oe", 32'(pa_oe), 32'h81);
        wr(5, 32'hFF);
        chk("R3 oe set", 32'(pa_oe), 32'(8'h81 | CHG_A));
        wr(6, 32'h30);
        chk("R4 oe clear", 32'(pa_oe), 32'((8'h81 | CHG_A) & ~(8'h30 & CHG_A)));

        // R11 write-only offsets read zero
        rd(3, v); chk("R11 set reads 0", v, 0);
        rd(6, v); chk("R11 clear reads 0", v, 0);
        rd(A_ACK, v); chk("R11 ack reads 0", v, 0);

        // wide ports
        for (int p = 1; p <= 4; p++) begin
            logic [17:0] chg, exp;
            chg = CHG_W[(p-1)*18 +: 18];
            wr(p*8 + 0, 32'h0);
            wr(p*8 + 3, 32'h3FFFF);
            chk("R3 wide set", 32'(pw_out[(p-1)*18 +: 18]), 32'(chg));
            wr(p*8 + 4, 32'h0F0F0);
            exp = chg & ~(18'h0F0F0 & chg);
            rd(p*8 + 0, v); chk("R4 wide clear", v, 32'(exp));
            wr(p*8 + 0, 32'h12345);
            rd(p*8 + 0, v); chk("R2 wide full write", v, 32'h12345);
            wr(p*8 + 5, 32'h3FFFF);
            chk("R3 wide oe set", 32'(pw_oe[(p-1)*18 +: 18]), 32'(chg));
            wr(p*8 + 6, 32'h3FFFF);
            chk("R4 wide oe clear", 32'(pw_oe[(p-1)*18 +: 18]), 0);
            pw_in[(p-1)*18 +: 18] = 18'(32'h2B3C1 + p);
            tick(2);
            rd(p*8 + 1, v); chk("R5 wide din", v, 32'h2B3C1 + 32'(p));
        end

        // R5 input latency on the narrow port
        pa_in = 8'h5A;
        tick(1);
        rd(1, v); chk("R5 din after one edge", v, 0);
        tick(1);
        rd(1, v); chk("R5 din after two edges", v, 32'h5A);
        pa_in = 8'h00;
        tick(4);

        // R6 field positions: pin i uses mode i, pin 7 uses code 7
        wr(A_CFG, 32'({3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}));
        wr(A_ACK, 32'hFF);
        pa_in = 8'hFF; tick(4);
        rd(A_RAW, v); chk("R6 mixed modes high", v, 32'h5A);
        pa_in = 8'h00; tick(4);
        rd(A_RAW, v); chk("R6 mixed modes low", v, 32'h7C);

        // R7/R8/R9 sweep over every mode code
        wr(A_MASK, 32'hFF);
        for (int m = 0; m < 8; m++) begin
            wr(A_CFG, 32'({8{3'(m)}}));
            pa_in = 8'h00; tick(4);
            wr(A_ACK, 32'hFF);
            pend = 8'h00; cur = 8'h00;
            for (int k = 0; k < 5; k++) begin
                pend = pend | f_ev(m, cur, pats[k]);
                cur = pats[k];
                pa_in = cur;
                tick(4);
                rd(A_RAW, v);
                if (m >= 4) chk("R8 edge sticky", v, 32'(pend | f_lvl(m, cur)));
                else        chk("R7 level live", v, 32'(pend | f_lvl(m, cur)));
                rd(A_MSTAT, v); chk("R10 full mask", v, 32'(pend | f_lvl(m, cur)));
            end
            wr(A_ACK, 32'h00);
            rd(A_RAW, v); chk("R9 ack zero no effect", v, 32'(pend | f_lvl(m, cur)));
            wr(A_ACK, 32'h55);
            pend = pend & 8'hAA;
            rd(A_RAW, v); chk("R9 ack clears ones", v, 32'(pend | f_lvl(m, cur)));
        end

        // R8 pending bit timing and R9 collision with a new edge
        pa_in = 8'h00;
        wr(A_CFG, 32'({8{3'd4}}));
        tick(4);
        wr(A_ACK, 32'hFF);
        pa_in = 8'h01;
        tick(2);
        rd(A_RAW, v); chk("R8 pending not yet", v, 0);
        wr(A_ACK, 32'h01);
        rd(A_RAW, v); chk("R9 edge beats ack", v, 32'h01);
        wr(A_ACK, 32'h01);
        rd(A_RAW, v); chk("R9 ack clears", v, 0);

        // R10 masking
        wr(A_CFG, 32'({8{3'd3}}));
        wr(A_MASK, 32'h0F);
        rd(A_MSTAT, v); chk("R10 masked status", v, 32'h0F);
        chk("R10 irq high", 32'(irq), 1);
        wr(A_MASK, 32'h00);
        rd(A_MSTAT, v); chk("R10 masked zero", v, 0);
        chk("R10 irq low", 32'(irq), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule